// File: doc/BRIEF.md
# Full-Speed USB Host Frame Timer

This block keeps the 1 ms frame clock of a full-speed USB host controller. A 14-bit remaining-time counter steps down once for each bit-time tick. When it passes zero it reloads from a programmable interval, and that reload is the frame boundary. Each boundary advances a 16-bit frame number. It then runs a fixed handshake sequence: first a start-of-frame token request, then a request to store the new frame number in the memory area shared with software, and last a sticky status flag. While this sequence is busy, a hold output keeps the list processor from fetching its first descriptor of the frame.

The block also guides the list processor. Once the remaining time falls to a programmed point, it raises a periodic-priority indication. This happens only when no control or bulk transaction is in flight. The indication drops at the next boundary. A low-speed permission output shows whether enough of the frame is left to begin a low-speed transaction. Software sets the interval, the periodic point and the low-speed threshold through a small register port. It reads back the counters, clears the flag, and can preset the frame number while the controller is halted.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the frame number, the remaining count, the flag and all request, hold and guidance outputs are 0. The register port reads the interval as 0x2EDF, the periodic point as 0 and the low-speed threshold as 0x628.
- R2: On the cycle after `run_en` rises, the frame number has gone up by one and the remaining count holds the interval. A boundary sequence starts from this event.
- R3: While `run_en` is high, each `bit_tick` lowers the remaining count by one. A tick that finds the count at 0 instead reloads the interval and advances the frame number, with 0xFFFF wrapping to 0x0000. Ticks are ignored while `run_en` is low.
- R4: After a boundary, `sof_req` rises and stays high until `sof_ack`. Only after that does `fn_wr_req` rise, with `fn_wr_data` equal to the new frame number, and it stays high until `fn_wr_ack`. The two requests are never high together.
- R5: `sof_flag` sets two cycles after the cycle in which `fn_wr_ack` meets `fn_wr_req`, never earlier. `list_hold` is high from the boundary until that acknowledge.
- R6: Writing a 1 to bit 0 of the status register (address 5) clears `sof_flag`. A flag set in the same cycle wins over the clear.
- R7: When the remaining count equals the periodic point, `periodic_pri` rises on the next cycle in which `xfer_active` is low. While `xfer_active` stays high the change waits.
- R8: `periodic_pri` is low on the cycle after each boundary.
- R9: `ls_ok` is high exactly when the controller runs and the remaining count of the previous cycle is at least the low-speed threshold (equality allows).
- R10: The registers sit at these addresses: 0 interval, 1 periodic point, 2 low-speed threshold, 3 frame number, 4 remaining count (read only), 5 status. Read data appears one cycle after `reg_rd`. A frame-number write takes effect only while `run_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per full-speed bit time |
| run_en | input | 1 | Controller in operational state |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid the cycle after `reg_rd` |
| sof_req | output | 1 | Start-of-frame token request |
| sof_ack | input | 1 | Token request accepted |
| fn_wr_req | output | 1 | Shared-memory frame-number write request |
| fn_wr_ack | input | 1 | Memory write completed |
| fn_wr_data | output | 16 | Frame number to store |
| list_hold | output | 1 | List processor must not fetch descriptors |
| sof_flag | output | 1 | Sticky start-of-frame status |
| xfer_active | input | 1 | Control/bulk transaction in progress |
| periodic_pri | output | 1 | Periodic lists have priority |
| ls_ok | output | 1 | Low-speed transaction may start |
| frame_num | output | 16 | Current frame number |
| frame_rem | output | 14 | Remaining bit times in the frame |

## Verification
Two events can fall in the same cycle. One is the status flag being set at the end of a boundary sequence; the other is a software write-1-to-clear of that flag. The bench turns off its automatic responder and acknowledges the token and memory requests by hand. It places the clear write exactly in the cycle where the set arrives, then expects the flag to read 1, and expects a later lone clear to read 0. A second overlap is tested too: a boundary and a pending priority change meeting in one cycle. The bench makes the periodic point equal the interval, so the point is reached in the boundary cycle, and it expects the indication to be low right after the boundary and high one cycle later.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef logic [ADDR_W-1:0] reg_adr_t;

  localparam reg_adr_t ADR_IVAL  = 3'd0;
  localparam reg_adr_t ADR_PSTRT = 3'd1;
  localparam reg_adr_t ADR_LSTHR = 3'd2;
  localparam reg_adr_t ADR_FNUM  = 3'd3;
  localparam reg_adr_t ADR_REM   = 3'd4;
  localparam reg_adr_t ADR_STAT  = 3'd5;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SOF  = 2'd1,
    SQ_WR   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/frm_regs.sv
module frm_regs
  import frm_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REM_W     = 14,
  parameter int unsigned FN_W      = 16,
  parameter int unsigned THR_W     = 12,
  parameter logic [REM_W-1:0] IVAL_RST  = 14'h2EDF,
  parameter logic [THR_W-1:0] LSTHR_RST = 12'h628
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  reg_adr_t          reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [FN_W-1:0]   fnum,
  input  logic [REM_W-1:0]  rem,
  input  logic              flag_set,
  output logic [REM_W-1:0]  ival,
  output logic [REM_W-1:0]  pstart,
  output logic [THR_W-1:0]  ls_thr,
  output logic              flag,
  output logic              fn_wr,
  output logic [FN_W-1:0]   fn_wdata
);
  logic wr_ival, wr_pst, wr_thr, clr_flag;

  assign wr_ival  = reg_wr && (reg_addr == ADR_IVAL);
  assign wr_pst   = reg_wr && (reg_addr == ADR_PSTRT);
  assign wr_thr   = reg_wr && (reg_addr == ADR_LSTHR);
  assign clr_flag = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[0];
  assign fn_wr    = reg_wr && (reg_addr == ADR_FNUM);
  assign fn_wdata = reg_wdata[FN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ival   <= IVAL_RST;
      pstart <= '0;
      ls_thr <= LSTHR_RST;
      flag   <= 1'b0;
    end else begin
      if (wr_ival) ival   <= reg_wdata[REM_W-1:0];
      if (wr_pst)  pstart <= reg_wdata[REM_W-1:0];
      if (wr_thr)  ls_thr <= reg_wdata[THR_W-1:0];
      // a set from the sequencer outranks a simultaneous clear
      if (flag_set)      flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADR_IVAL:  reg_rdata <= DATA_W'(ival);
        ADR_PSTRT: reg_rdata <= DATA_W'(pstart);
        ADR_LSTHR: reg_rdata <= DATA_W'(ls_thr);
        ADR_FNUM:  reg_rdata <= DATA_W'(fnum);
        ADR_REM:   reg_rdata <= DATA_W'(rem);
        ADR_STAT:  reg_rdata <= DATA_W'(flag);
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/frm_counter.sv
module frm_counter #(
  parameter int unsigned REM_W = 14,
  parameter int unsigned FN_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [REM_W-1:0] ival,
  input  logic             fn_wr,
  input  logic [FN_W-1:0]  fn_wdata,
  output logic [REM_W-1:0] rem,
  output logic [FN_W-1:0]  fnum,
  output logic             bnd
);
  logic run_q;
  logic run_rise;

  assign run_rise = run && !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      fnum  <= '0;
      bnd   <= 1'b0;
      run_q <= 1'b0;
    end else begin
      run_q <= run;
      bnd   <= 1'b0;
      if (run_rise) begin
        rem  <= ival;
        fnum <= fnum + 1'b1;
        bnd  <= 1'b1;
      end else if (run && tick) begin
        if (rem == '0) begin
          rem  <= ival;
          fnum <= fnum + 1'b1;
          bnd  <= 1'b1;
        end else begin
          rem <= rem - 1'b1;
        end
      end else if (!run && fn_wr) begin
        fnum <= fn_wdata;
      end
    end
  end
endmodule

// File: rtl/frm_sof_seq.sv
module frm_sof_seq
  import frm_pkg::*;
#(
  parameter int unsigned FN_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bnd,
  input  logic [FN_W-1:0] fnum,
  output logic            sof_req,
  input  logic            sof_ack,
  output logic            wr_req,
  input  logic            wr_ack,
  output logic [FN_W-1:0] wr_data,
  output logic            done,
  output logic            hold
);
  seq_state_t state;
  logic       pend;

  assign hold = (state != SQ_IDLE) || pend || bnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      pend    <= 1'b0;
      sof_req <= 1'b0;
      wr_req  <= 1'b0;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (bnd && state != SQ_IDLE) pend <= 1'b1;
      case (state)
        SQ_IDLE: begin
          if (bnd || pend) begin
            state   <= SQ_SOF;
            sof_req <= 1'b1;
            pend    <= 1'b0;
          end
        end
        SQ_SOF: begin
          if (sof_ack) begin
            sof_req <= 1'b0;
            wr_req  <= 1'b1;
            wr_data <= fnum;
            state   <= SQ_WR;
          end
        end
        SQ_WR: begin
          if (wr_ack) begin
            wr_req <= 1'b0;
            done   <= 1'b1;
            state  <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frm_arbiter.sv
module frm_arbiter #(
  parameter int unsigned REM_W = 14,
  parameter int unsigned THR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             bnd,
  input  logic [REM_W-1:0] rem,
  input  logic [REM_W-1:0] pstart,
  input  logic [THR_W-1:0] ls_thr,
  input  logic             xfer_active,
  output logic             pri,
  output logic             ls_ok
);
  logic hit, pend, pend_d, pri_n;

  assign hit    = run && (rem == pstart);
  assign pend_d = (bnd ? 1'b0 : pend) | hit;
  assign pri_n  = bnd ? 1'b0 : (pri | (pend_d & ~xfer_active));

  always_ff @(posedge clk) begin
    if (rst) begin
      pri   <= 1'b0;
      pend  <= 1'b0;
      ls_ok <= 1'b0;
    end else begin
      pri   <= pri_n;
      pend  <= pend_d & ~pri_n;
      ls_ok <= run && (rem >= REM_W'(ls_thr));
    end
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import frm_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REM_W  = 14,
  parameter int unsigned FN_W   = 16,
  parameter int unsigned THR_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              run_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sof_req,
  input  logic              sof_ack,
  output logic              fn_wr_req,
  input  logic              fn_wr_ack,
  output logic [FN_W-1:0]   fn_wr_data,
  output logic              list_hold,
  output logic              sof_flag,
  input  logic              xfer_active,
  output logic              periodic_pri,
  output logic              ls_ok,
  output logic [FN_W-1:0]   frame_num,
  output logic [REM_W-1:0]  frame_rem
);
  logic [REM_W-1:0] ival, pstart;
  logic [THR_W-1:0] thr_q;
  logic             fn_wr, bnd, done;
  logic [FN_W-1:0]  fn_wdata;

  frm_regs #(
    .DATA_W(DATA_W), .REM_W(REM_W), .FN_W(FN_W), .THR_W(THR_W)
  ) i_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fnum(frame_num), .rem(frame_rem), .flag_set(done),
    .ival(ival), .pstart(pstart), .ls_thr(thr_q), .flag(sof_flag),
    .fn_wr(fn_wr), .fn_wdata(fn_wdata)
  );

  frm_counter #(.REM_W(REM_W), .FN_W(FN_W)) i_cnt (
    .clk(clk), .rst(rst), .run(run_en), .tick(bit_tick), .ival(ival),
    .fn_wr(fn_wr), .fn_wdata(fn_wdata), .rem(frame_rem), .fnum(frame_num),
    .bnd(bnd)
  );

  frm_sof_seq #(.FN_W(FN_W)) i_seq (
    .clk(clk), .rst(rst), .bnd(bnd), .fnum(frame_num),
    .sof_req(sof_req), .sof_ack(sof_ack), .wr_req(fn_wr_req),
    .wr_ack(fn_wr_ack), .wr_data(fn_wr_data), .done(done), .hold(list_hold)
  );

  frm_arbiter #(.REM_W(REM_W), .THR_W(THR_W)) i_arb (
    .clk(clk), .rst(rst), .run(run_en), .bnd(bnd), .rem(frame_rem),
    .pstart(pstart), .ls_thr(thr_q), .xfer_active(xfer_active),
    .pri(periodic_pri), .ls_ok(ls_ok)
  );
endmodule

module frm_timer_chk #(
  parameter int unsigned REM_W = 14,
  parameter int unsigned FN_W  = 16,
  parameter int unsigned THR_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             sof_req,
  input logic             sof_ack,
  input logic             fn_wr_req,
  input logic             fn_wr_ack,
  input logic             sof_flag,
  input logic             xfer_active,
  input logic             periodic_pri,
  input logic             ls_ok,
  input logic [FN_W-1:0]  frame_num,
  input logic [REM_W-1:0] frame_rem,
  input logic [THR_W-1:0] ls_thr
);
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sof_req && fn_wr_req)); // R4
  AST_SOF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sof_req && !sof_ack) |=> sof_req); // R4
  AST_WR_AFTER_SOF: assert property (@(posedge clk) disable iff (rst)
    $rose(fn_wr_req) |-> $past(sof_req && sof_ack)); // R4
  AST_FLAG_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    $rose(sof_flag) |-> $past(fn_wr_req && fn_wr_ack, 2)); // R5
  AST_RUN_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en) |=> (frame_num == FN_W'($past(frame_num) + 1'b1))); // R2
  AST_PRI_DEFER: assert property (@(posedge clk) disable iff (rst)
    $rose(periodic_pri) |-> !$past(xfer_active)); // R7
  AST_PRI_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (run_en && $past(run_en) && frame_num != $past(frame_num)) |=> !periodic_pri); // R8
  AST_LS_GATE: assert property (@(posedge clk) disable iff (rst)
    ls_ok |-> ($past(frame_rem) >= REM_W'($past(ls_thr)))); // R9
endmodule

bind usb_frame_timer frm_timer_chk #(.REM_W(REM_W), .FN_W(FN_W), .THR_W(THR_W)) i_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .sof_req(sof_req), .sof_ack(sof_ack),
  .fn_wr_req(fn_wr_req), .fn_wr_ack(fn_wr_ack), .sof_flag(sof_flag),
  .xfer_active(xfer_active), .periodic_pri(periodic_pri), .ls_ok(ls_ok),
  .frame_num(frame_num), .frame_rem(frame_rem), .ls_thr(thr_q)
);

// File: tb/test_usb_frame_timer.sv
module test_usb_frame_timer;
  logic        clk = 1'b0, rst = 1'b1;
  logic        bit_tick = 1'b0, run_en = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        sof_req, sof_ack = 1'b0, fn_wr_req, fn_wr_ack = 1'b0;
  logic [15:0] fn_wr_data, frame_num;
  logic [13:0] frame_rem;
  logic        list_hold, sof_flag, xfer_active = 1'b0, periodic_pri, ls_ok;

  int   n_chk = 0, n_err = 0;
  bit   auto_ack = 1'b1, finished = 1'b0;
  logic [15:0] m_fn = '0;
  logic [13:0] m_rem = '0, m_ival = 14'h2EDF, m_pst = '0;
  logic [11:0] m_thr = 12'h628;
  bit   m_run = 1'b0;

  always #5 clk = ~clk;

  usb_frame_timer i_usb_frame_timer (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .run_en(run_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sof_req(sof_req),
    .sof_ack(sof_ack), .fn_wr_req(fn_wr_req), .fn_wr_ack(fn_wr_ack),
    .fn_wr_data(fn_wr_data), .list_hold(list_hold), .sof_flag(sof_flag),
    .xfer_active(xfer_active), .periodic_pri(periodic_pri), .ls_ok(ls_ok),
    .frame_num(frame_num), .frame_rem(frame_rem)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ls(input logic [13:0] r, input logic [11:0] t, input bit run);
    return run && (r >= {2'b00, t});
  endfunction

  function automatic bit exp_pri(input logic [13:0] r, input logic [13:0] p, input logic [13:0] iv);
    return (p <= iv) && (r <= p);
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // one tick, model update, then compare counters and guidance outputs
  task automatic do_tick();
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    if (m_run) begin
      if (m_rem == 0) begin m_rem = m_ival; m_fn = m_fn + 1'b1; end
      else m_rem = m_rem - 1'b1;
    end
    repeat (2) @(negedge clk);
    check(frame_rem == m_rem, "R3 remaining", frame_rem, m_rem);
    check(frame_num == m_fn, "R3 frame number", frame_num, m_fn);
    check(ls_ok == exp_ls(m_rem, m_thr, m_run), "R9 low-speed gate", ls_ok, exp_ls(m_rem, m_thr, m_run));
    if (!xfer_active && m_run)
      check(periodic_pri == exp_pri(m_rem, m_pst, m_ival), "R7 priority", periodic_pri, exp_pri(m_rem, m_pst, m_ival));
  endtask

  task automatic go_run();
    @(negedge clk); run_en = 1'b1;
    m_run = 1'b1; m_fn = m_fn + 1'b1; m_rem = m_ival;
    repeat (3) @(negedge clk);
    check(frame_num == m_fn, "R2 number on run", frame_num, m_fn);
    check(frame_rem == m_rem, "R2 reload on run", frame_rem, m_rem);
  endtask

  task automatic halt();
    wait (!sof_req && !fn_wr_req && !list_hold);
    @(negedge clk); run_en = 1'b0; m_run = 1'b0;
  endtask

  task automatic setup(input logic [13:0] iv, input logic [13:0] ps, input logic [11:0] th);
    wr_reg(3'd0, {2'b00, iv}); m_ival = iv;
    wr_reg(3'd1, {2'b00, ps}); m_pst = ps;
    wr_reg(3'd2, {4'h0, th});  m_thr = th;
  endtask

  // automatic handshake partner; checks stored data against the model
  always begin
    @(negedge clk);
    if (auto_ack && sof_req) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      sof_ack = 1'b1; @(negedge clk); sof_ack = 1'b0;
    end else if (auto_ack && fn_wr_req) begin
      check(fn_wr_data == m_fn, "R4 stored frame number", fn_wr_data, m_fn);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      fn_wr_ack = 1'b1; @(negedge clk); fn_wr_ack = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(frame_num == 0 && frame_rem == 0, "R1 counters", {frame_num, 2'b00, frame_rem}, 0);
    check(!sof_req && !fn_wr_req && !list_hold && !sof_flag, "R1 sequence idle", {sof_req, fn_wr_req, list_hold, sof_flag}, 0);
    check(!periodic_pri && !ls_ok, "R1 guidance", {periodic_pri, ls_ok}, 0);
    rd_reg(3'd0, d); check(d == 16'h2EDF, "R1 interval reset", d, 16'h2EDF);
    rd_reg(3'd2, d); check(d == 16'h0628, "R1 threshold reset", d, 16'h0628);
    rd_reg(3'd1, d); check(d == 16'h0000, "R1 periodic reset", d, 0);
    // R3 ticks ignored while halted
    do_tick();
    // R10 preset the frame number while halted, read it back
    setup(14'd20, 14'd12, 12'd8);
    wr_reg(3'd3, 16'hFFFE); m_fn = 16'hFFFE;
    rd_reg(3'd3, d); check(d == 16'hFFFE, "R10 frame number preset", d, 16'hFFFE);
    rd_reg(3'd0, d); check(d == 16'd20, "R10 interval readback", d, 20);
    go_run();
    wait (sof_flag);
    check(sof_flag == 1'b1, "R5 flag after first sequence", sof_flag, 1);
    // R3 wrap from 0xFFFF to 0x0000 across the next boundary
    for (int i = 0; i < 21; i++) do_tick();
    check(frame_num == 16'h0000, "R3 wrap", frame_num, 0);
    rd_reg(3'd4, d); check(d == {2'b00, m_rem}, "R10 remaining readback", d, m_rem);
    // R10 frame number write while running has no effect
    wr_reg(3'd3, 16'h1234);
    rd_reg(3'd3, d); check(d == m_fn, "R10 write ignored while running", d, m_fn);
    // R6 plain clear
    wait (!list_hold);
    wr_reg(3'd5, 16'h0001);
    @(negedge clk);
    check(sof_flag == 1'b0, "R6 clear", sof_flag, 0);

    // R5/R6 manual handshake, clear collides with set
    auto_ack = 1'b0;
    while (m_rem != 0) do_tick();
    do_tick();
    check(sof_req && !fn_wr_req, "R4 token first", {sof_req, fn_wr_req}, 2);
    check(list_hold == 1'b1, "R5 hold during token", list_hold, 1);
    repeat (2) @(negedge clk);
    check(sof_req == 1'b1, "R4 token held until ack", sof_req, 1);
    sof_ack = 1'b1; @(negedge clk); sof_ack = 1'b0;
    check(fn_wr_req && !sof_req, "R4 write after token", {sof_req, fn_wr_req}, 1);
    check(fn_wr_data == m_fn, "R4 write data", fn_wr_data, m_fn);
    repeat (2) @(negedge clk);
    check(sof_flag == 1'b0 && list_hold, "R5 no flag before write ack", {sof_flag, list_hold}, 1);
    fn_wr_ack = 1'b1; @(negedge clk); fn_wr_ack = 1'b0;
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 16'h0001;
    @(negedge clk); reg_wr = 1'b0;
    check(sof_flag == 1'b1, "R6 set wins over clear", sof_flag, 1);
    check(list_hold == 1'b0, "R5 hold released", list_hold, 0);
    wr_reg(3'd5, 16'h0001); @(negedge clk);
    check(sof_flag == 1'b0, "R6 clear after collision", sof_flag, 0);
    auto_ack = 1'b1;

    // R7 deferral while a transaction is active
    @(negedge clk); xfer_active = 1'b1;
    while (m_rem != 0) do_tick();
    do_tick();
    check(periodic_pri == 1'b0, "R8 cleared at boundary", periodic_pri, 0);
    while (m_rem != m_pst - 2) do_tick();
    check(periodic_pri == 1'b0, "R7 held off by transaction", periodic_pri, 0);
    @(negedge clk); xfer_active = 1'b0;
    repeat (2) @(negedge clk);
    check(periodic_pri == 1'b1, "R7 applied after transaction", periodic_pri, 1);
    while (m_rem != 0) do_tick();
    do_tick();
    check(periodic_pri == 1'b0, "R8 drop at boundary", periodic_pri, 0);
    // R9 equality edge of the low-speed threshold
    while (m_rem != {2'b00, m_thr}) do_tick();
    check(ls_ok == 1'b1, "R9 equal allows", ls_ok, 1);
    do_tick();
    check(ls_ok == 1'b0, "R9 below blocks", ls_ok, 0);

    // R7/R8 periodic point equal to the interval: boundary and hit coincide
    halt();
    setup(14'd16, 14'd16, 12'd4);
    go_run();
    check(periodic_pri == 1'b1, "R7 hit in boundary cycle", periodic_pri, 1);

    // constrained random rounds
    for (int r = 0; r < 8; r++) begin
      halt();
      setup(14'($urandom_range(8, 40)), 14'($urandom_range(0, 45)), 12'($urandom_range(0, 45)));
      go_run();
      for (int k = 0; k < int'($urandom_range(30, 90)); k++) do_tick();
    end
    halt();
    // R3 ticks while halted do nothing
    do_tick();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule